// File: doc/BRIEF.md
# Serial Converter Frame and Power-Mode Sequencer

This block is the digital timing core of a sampling serial converter. The converted value reaches it as a parallel signed word. A fast system clock oversamples the two pins that the host drives, the serial clock pin and the convert pin. Each pin passes through a two-flop synchronizer and a rising-edge detector. A convert rising edge that is accepted clamps the input word to the unsigned output range and latches it. The block then counts serial-clock rising edges. Two lead edges pass with the data line released. The captured code then goes out MSB first on a tri-stateable data line, one slot per serial-clock rising edge. The lockout lasts sixteen edges.

A second state machine watches the two pins for power-mode requests. Consecutive convert edges with no serial-clock edge between them first move the block into a nap state and then into a sleep state. Any serial-clock edge brings it back to the active state. Resolution is 14 or 12 bits, chosen by the parameter `RES_BITS`. In the 12-bit build the data slots end with two padding slots.

The frame machine has four states. FR_IDLE releases the line. FR_LEAD is busy and still released. FR_DATA is busy and drives the line. FR_TAIL is no longer busy but still drives the final slot. The transitions are:
- IDLE→LEAD and TAIL→LEAD on an accepted convert edge.
- LEAD→DATA on the third serial-clock edge.
- DATA→TAIL on the sixteenth serial-clock edge.
- TAIL→IDLE on the next serial-clock edge.

The power machine has three states: PM_ACTIVE, PM_NAP and PM_SLEEP. It moves ACTIVE→NAP when the run count reaches 2 and NAP→SLEEP when it reaches 4. Any state returns to ACTIVE on a serial-clock edge.

Top module: `serial_adc_timing`

## Requirements
- R1: A convert rising edge seen in FR_IDLE or FR_TAIL latches the clamped input word and raises `busy`. Further convert edges leave the frame and the latched word untouched until 16 serial-clock rising edges have been counted. `busy` falls on the 16th of those edges.
- R2: The first data slot appears on `sdo` at the 3rd serial-clock rising edge after the frame start. It carries the MSB, and each later edge presents the next lower bit.
- R3: A frame has 14 data slots. With `RES_BITS`=14 they carry bit 13 down to bit 0. With `RES_BITS`=12 they carry bit 11 down to bit 0, followed by two slots driven low.
- R4: `sdo` is high impedance, with `sdo_oe` low, in four situations: after reset, before any frame, during the two lead edges, and from the first serial-clock rising edge after the 16th until the next frame drives data.
- R5: Two convert rising edges with no serial-clock rising edge between them set `pwr_mode` to nap. Four or more such edges set it to sleep. The encoding is active=0, nap=1, sleep=2, and 3 never appears.
- R6: Any serial-clock rising edge returns `pwr_mode` to active and clears the run of convert edges.
- R7: The captured code is straight binary. A signed input below zero gives all zeros, and an input above 2^RES_BITS−1 gives all ones.
- R8: Reset leaves `pwr_mode` active, `busy` low and `sdo` released.
- R9: When convert and serial-clock rising edges reach the detectors in the same system cycle, two things happen. A frame start in FR_IDLE or FR_TAIL wins, and that serial-clock edge is not counted toward the new frame. The power machine wakes to active and counts the convert edge as the first of a new run.
- R10: After the 16th edge the final slot stays driven with `busy` low. A convert edge in that state starts a new frame at once and releases `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| conv_pin | input | 1 | Convert pin, asynchronous |
| sample_in | input | RES_BITS+2 | Signed converter value, clamped on capture |
| sdo | output | 1 | Serial data, high impedance when not driving |
| sdo_oe | output | 1 | High while `sdo` is driven |
| busy | output | 1 | High from frame start until the 16th serial-clock edge |
| pwr_mode | output | 2 | 0 active, 1 nap, 2 sleep |

## Verification
The clash of interest is a convert edge and a serial-clock edge detected in the same system cycle. This affects both the frame counter and the power run counter. The bench provokes it by changing both pins at the same instant, so the two synchronizers deliver both edges together. It does this once while the block is napping and once while it sits in FR_TAIL. In the first case it is judged by `pwr_mode` reading active and then nap after one more lone convert edge. In the second case it is judged by the new word appearing only on the third later serial-clock edge.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_NAP    = 2'd1,
        PM_SLEEP  = 2'd2
    } pm_t;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_LEAD = 2'd1,
        FR_DATA = 2'd2,
        FR_TAIL = 2'd3
    } fr_t;
endpackage

// File: rtl/pin_edge.sv
module pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], pin};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/code_clamp.sv
module code_clamp #(
    parameter int RES_BITS = 14,
    parameter int IN_W     = RES_BITS + 2
) (
    input  logic signed [IN_W-1:0]     raw,
    output logic        [RES_BITS-1:0] code
);
    localparam logic signed [IN_W-1:0] FULL_S = IN_W'((1 << RES_BITS) - 1);

    always_comb begin
        if (raw < 0)           code = '0;
        else if (raw > FULL_S) code = '1;
        else                   code = raw[RES_BITS-1:0];
    end
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import sadc_pkg::*;
#(
    parameter int RES_BITS    = 14,
    parameter int FRAME_EDGES = 16,
    parameter int LEAD_EDGES  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                conv_rise,
    input  logic                sck_rise,
    input  logic [RES_BITS-1:0] code,
    output logic                sdo_bit,
    output logic                sdo_oe,
    output logic                busy
);
    localparam int SLOTS = FRAME_EDGES - LEAD_EDGES;
    localparam int CW    = $clog2(FRAME_EDGES + 1);

    fr_t              st, st_n;
    logic [CW-1:0]    cnt, cnt_n;
    logic [SLOTS-1:0] sh, sh_n;
    logic [SLOTS-1:0] padded;

    generate
        if (RES_BITS == SLOTS) begin : g_full
            assign padded = code;
        end else begin : g_pad
            assign padded = {code, {(SLOTS-RES_BITS){1'b0}}};
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= FR_IDLE;
            cnt <= '0;
            sh  <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            sh  <= sh_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        sh_n  = sh;
        unique case (st)
            FR_IDLE, FR_TAIL: begin
                if (conv_rise) begin
                    st_n  = FR_LEAD;
                    cnt_n = '0;
                    sh_n  = padded;
                end else if (sck_rise && st == FR_TAIL) begin
                    st_n = FR_IDLE;
                end
            end
            FR_LEAD: begin
                if (sck_rise) begin
                    cnt_n = cnt + CW'(1);
                    if (cnt_n == CW'(LEAD_EDGES + 1)) st_n = FR_DATA;
                end
            end
            FR_DATA: begin
                if (sck_rise) begin
                    cnt_n = cnt + CW'(1);
                    sh_n  = sh << 1;
                    if (cnt_n == CW'(FRAME_EDGES)) st_n = FR_TAIL;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        sdo_oe  = (st == FR_DATA) || (st == FR_TAIL);
        busy    = (st == FR_LEAD) || (st == FR_DATA);
        sdo_bit = sh[SLOTS-1];
    end
endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
    import sadc_pkg::*;
#(
    parameter int NAP_RUN   = 2,
    parameter int SLEEP_RUN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_rise,
    input  logic       sck_rise,
    output logic [1:0] mode
);
    localparam int RW = $clog2(SLEEP_RUN + 1);

    pm_t           st, st_n;
    logic [RW-1:0] run, run_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PM_ACTIVE;
            run <= '0;
        end else begin
            st  <= st_n;
            run <= run_n;
        end
    end

    always_comb begin
        st_n  = st;
        run_n = run;
        if (sck_rise) begin
            st_n  = PM_ACTIVE;
            run_n = conv_rise ? RW'(1) : '0;
        end else if (conv_rise) begin
            run_n = (run == RW'(SLEEP_RUN)) ? run : run + RW'(1);
            unique case (st)
                PM_ACTIVE: if (run_n == RW'(NAP_RUN))   st_n = PM_NAP;
                PM_NAP:    if (run_n == RW'(SLEEP_RUN)) st_n = PM_SLEEP;
                PM_SLEEP:  st_n = PM_SLEEP;
                default:   st_n = PM_ACTIVE;
            endcase
        end
    end

    always_comb mode = st;
endmodule

// File: rtl/serial_adc_timing.sv
module serial_adc_timing #(
    parameter int RES_BITS    = 14,
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_EDGES = 16,
    parameter int LEAD_EDGES  = 2,
    parameter int NAP_RUN     = 2,
    parameter int SLEEP_RUN   = 4,
    localparam int IN_W       = RES_BITS + 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sck_pin,
    input  logic                   conv_pin,
    input  logic signed [IN_W-1:0] sample_in,
    output wire                    sdo,
    output logic                   sdo_oe,
    output logic                   busy,
    output logic [1:0]             pwr_mode
);
    logic                sck_rise, conv_rise, sdo_bit;
    logic [RES_BITS-1:0] code;

    pin_edge #(.STAGES(SYNC_STAGES)) u_sck_edge (
        .clk(clk), .rst(rst), .pin(sck_pin), .rise(sck_rise));
    pin_edge #(.STAGES(SYNC_STAGES)) u_conv_edge (
        .clk(clk), .rst(rst), .pin(conv_pin), .rise(conv_rise));

    code_clamp #(.RES_BITS(RES_BITS), .IN_W(IN_W)) u_clamp (
        .raw(sample_in), .code(code));

    frame_ctrl #(.RES_BITS(RES_BITS), .FRAME_EDGES(FRAME_EDGES),
                 .LEAD_EDGES(LEAD_EDGES)) u_frame (
        .clk(clk), .rst(rst), .conv_rise(conv_rise), .sck_rise(sck_rise),
        .code(code), .sdo_bit(sdo_bit), .sdo_oe(sdo_oe), .busy(busy));

    pwr_ctrl #(.NAP_RUN(NAP_RUN), .SLEEP_RUN(SLEEP_RUN)) u_pwr (
        .clk(clk), .rst(rst), .conv_rise(conv_rise), .sck_rise(sck_rise),
        .mode(pwr_mode));

    assign sdo = sdo_oe ? sdo_bit : 1'bz;
endmodule

// File: rtl/serial_adc_timing_chk.sv
module serial_adc_timing_chk (
    input logic       clk,
    input logic       rst,
    input logic       sck_rise,
    input logic       conv_rise,
    input logic       busy,
    input logic       sdo_oe,
    input logic [1:0] pwr_mode
);
    p_reset_state_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pwr_mode == 2'd0 && !busy && !sdo_oe));

    p_busy_holds_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && !sck_rise) |=> busy);

    p_start_released_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !sdo_oe);

    p_data_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> busy);

    p_wake_r6: assert property (@(posedge clk) disable iff (rst)
        sck_rise |=> (pwr_mode == 2'd0));

    p_mode_code_r5: assert property (@(posedge clk) disable iff (rst)
        pwr_mode != 2'd3);

    p_sleep_from_nap_r5: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd2 && $past(pwr_mode) != 2'd2) |->
        ($past(pwr_mode) == 2'd1 && $past(conv_rise)));
endmodule

bind serial_adc_timing serial_adc_timing_chk u_chk (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .conv_rise(conv_rise),
    .busy(busy), .sdo_oe(sdo_oe), .pwr_mode(pwr_mode));

// File: tb/serial_adc_timing_test.sv
module serial_adc_timing_test;
    logic clk = 0, rst = 1, sck = 0, conv = 0;
    logic signed [15:0] s14 = '0;
    logic signed [13:0] s12 = '0;
    wire  sdo14, sdo12;
    logic oe14, oe12, busy14, busy12;
    logic [1:0] pm14, pm12;
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    serial_adc_timing #(.RES_BITS(14)) uut (
        .clk(clk), .rst(rst), .sck_pin(sck), .conv_pin(conv), .sample_in(s14),
        .sdo(sdo14), .sdo_oe(oe14), .busy(busy14), .pwr_mode(pm14));
    serial_adc_timing #(.RES_BITS(12)) uut_w12 (
        .clk(clk), .rst(rst), .sck_pin(sck), .conv_pin(conv), .sample_in(s12),
        .sdo(sdo12), .sdo_oe(oe12), .busy(busy12), .pwr_mode(pm12));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] clamp14(input int v);
        if (v < 0) return '0;
        if (v > 16383) return 14'h3FFF;
        return 14'(v);
    endfunction
    function automatic logic [11:0] clamp12(input int v);
        if (v < 0) return '0;
        if (v > 4095) return 12'hFFF;
        return 12'(v);
    endfunction
    function automatic logic bit14(input logic [13:0] c, input int e);
        if (e < 3) return 1'bz;
        return c[16-e];
    endfunction
    function automatic logic bit12(input logic [11:0] c, input int e);
        if (e < 3) return 1'bz;
        if (e <= 14) return c[14-e];
        return 1'b0;
    endfunction

    task automatic set_in(input int a, input int b);
        s14 = 16'(a);
        s12 = 14'(b);
    endtask
    task automatic sck_pulse();
        sck = 1; repeat (4) @(negedge clk);
        sck = 0; repeat (4) @(negedge clk);
    endtask
    task automatic conv_pulse();
        conv = 1; repeat (4) @(negedge clk);
        conv = 0; repeat (4) @(negedge clk);
    endtask
    task automatic both_pulse();
        sck = 1; conv = 1; repeat (4) @(negedge clk);
        sck = 0; conv = 0; repeat (4) @(negedge clk);
    endtask
    task automatic flush();
        while (busy14) sck_pulse();
        sck_pulse();
    endtask

    // edges first_e..last_e of a frame, checking each slot (R1 R2 R3 R10)
    task automatic read_edges(input int first_e, input int last_e,
                              input logic [13:0] c14, input logic [11:0] c12, input string tag);
        for (int e = first_e; e <= last_e; e++) begin
            sck_pulse();
            check({tag, " R2 sdo14"}, {31'b0, sdo14}, {31'b0, bit14(c14, e)});
            check({tag, " R3 sdo12"}, {31'b0, sdo12}, {31'b0, bit12(c12, e)});
            check({tag, " R1 busy"}, {31'b0, busy14}, {31'b0, (e < 16)});
        end
    endtask

    task automatic t_reset();
        check("R8 mode", {30'b0, pm14}, 0);
        check("R8 busy", {31'b0, busy14}, 0);
        check("R4 sdo after reset", {31'b0, sdo14}, {31'b0, 1'bz});
        check("R4 oe after reset", {31'b0, oe14}, 0);
    endtask

    task automatic t_frame(input int a, input int b);
        set_in(a, b);
        conv_pulse();
        check("R1 busy at start", {31'b0, busy14}, 1);
        check("R4 released at start", {31'b0, sdo14}, {31'b0, 1'bz});
        read_edges(1, 16, clamp14(a), clamp12(b), "frame");
        check("R10 last slot held", {31'b0, oe14}, 1);
        sck_pulse();
        check("R4 released after frame", {31'b0, sdo14}, {31'b0, 1'bz});
        check("R4 oe after frame", {31'b0, oe12}, 0);
    endtask

    task automatic t_lockout();
        set_in(16'h2A5C, 12'hA5C);
        conv_pulse();
        read_edges(1, 5, 14'h2A5C, 12'hA5C, "lockout");
        set_in(16'h0F0F, 12'h0F0);
        conv_pulse();
        check("R1 busy kept", {31'b0, busy14}, 1);
        read_edges(6, 16, 14'h2A5C, 12'hA5C, "R1 lockout word");
        sck_pulse();
    endtask

    task automatic t_tail_restart();
        set_in(16'h1234, 12'h123);
        conv_pulse();
        read_edges(1, 16, 14'h1234, 12'h123, "tail");
        set_in(16'h3ACE, 12'hACE);
        conv_pulse();
        check("R10 restart busy", {31'b0, busy14}, 1);
        check("R10 restart released", {31'b0, sdo14}, {31'b0, 1'bz});
        read_edges(1, 16, 14'h3ACE, 12'hACE, "R10 new frame");
        sck_pulse();
    endtask

    task automatic t_power();
        conv_pulse();
        check("R5 one conv active", {30'b0, pm14}, 0);
        conv_pulse();
        check("R5 two conv nap", {30'b0, pm14}, 1);
        conv_pulse();
        check("R5 three conv nap", {30'b0, pm14}, 1);
        conv_pulse();
        check("R5 four conv sleep", {30'b0, pm14}, 2);
        conv_pulse();
        check("R5 five conv sleep", {30'b0, pm12}, 2);
        sck_pulse();
        check("R6 wake from sleep", {30'b0, pm14}, 0);
        conv_pulse();
        check("R6 run cleared", {30'b0, pm14}, 0);
        flush();
    endtask

    task automatic t_coincide();
        conv_pulse();
        conv_pulse();
        check("R5 nap before clash", {30'b0, pm14}, 1);
        both_pulse();
        check("R9 wake on clash", {30'b0, pm14}, 0);
        conv_pulse();
        check("R9 clash conv counted", {30'b0, pm14}, 1);
        flush();
        // clash in FR_TAIL: frame start wins, edge not counted
        set_in(16'h0155, 12'h055);
        conv_pulse();
        read_edges(1, 16, 14'h0155, 12'h055, "pre-clash");
        set_in(16'h3E07, 12'hE07);
        both_pulse();
        check("R9 clash starts frame", {31'b0, busy14}, 1);
        check("R9 clash released", {31'b0, sdo14}, {31'b0, 1'bz});
        read_edges(1, 16, 14'h3E07, 12'hE07, "R9 clash frame");
        sck_pulse();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_frame(16'h2A5C, 12'hA5C);
        t_frame(16'h1555, 12'h3C3);
        t_frame(-5, 5000);      // R7 clamps
        t_frame(20000, -1);     // R7 clamps
        t_lockout();
        t_tail_restart();
        t_power();
        t_coincide();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule